// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block tracks the reservations that load-exclusive and store-exclusive pairs rely on, for a small, parameterised set of requesters. Each requester owns one local reservation slot. It also owns one global reservation slot that covers memory visible to other agents. A reservation is a word address, a size code and the owning requester.

A mark request records a reservation. If the target is shareable, the mark fills both of the requester's slots; otherwise it fills only the local slot. A store-exclusive check asks whether the requester may complete its store. A clear-local request drops one requester's local slot. A snoop port sees ordinary stores to shareable memory and drops any global reservation they hit.

The check answer comes out one cycle after the request, as a pass bit and an alignment-fault bit qualified by a valid strobe. Translation, memory and decode sit outside the block.

Top module: `excl_monitor`

## Requirements
- R1: A mark with shareable=1 sets the requester's local and global reservation to (address, size). A mark with shareable=0 sets only the local one and leaves the global one as it was.
- R2: A check with shareable=0 passes only when the requester's local reservation is valid and holds exactly the checked address and size code.
- R3: A check with shareable=1 passes only when both the requester's local reservation and its global reservation are valid and hold exactly the checked address and size. A size mismatch fails.
- R4: A passing check clears the requester's local reservation, so an identical second check fails. A failing check changes no reservation.
- R5: The size code s means 2^s bytes. A check whose address is not a multiple of 2^s returns fault=1 and pass=0, and changes no reservation.
- R6: A clear-local request removes only the named requester's local reservation. Every other requester's reservation is kept.
- R7: A snoop store clears the global reservation of every requester whose global address and size both equal the snoop's. Local reservations are not touched, and a snoop that differs in size clears nothing.
- R8: Each requester holds one local reservation, and a new mark replaces it. When a mark to a requester arrives in the same cycle as a clear or a pass for that requester, the mark wins.
- R9: After reset no reservation exists and all outputs are low. res_vld is high exactly in the cycle after chk_vld. res_pass and res_fault are low whenever res_vld is low. A check is judged on the reservations held before the same cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mark_vld | input | 1 | Mark request |
| mark_pid | input | PW | Requester of the mark |
| mark_addr | input | AW | Address of the mark |
| mark_size | input | SW | Size code of the mark (2^code bytes) |
| mark_shr | input | 1 | Mark target is shareable |
| chk_vld | input | 1 | Store-exclusive check request |
| chk_pid | input | PW | Requester of the check |
| chk_addr | input | AW | Address of the check |
| chk_size | input | SW | Size code of the check |
| chk_shr | input | 1 | Check target is shareable |
| clr_vld | input | 1 | Clear-local request |
| clr_pid | input | PW | Requester whose local reservation is dropped |
| snp_vld | input | 1 | Ordinary store seen on shareable memory |
| snp_addr | input | AW | Snooped store address |
| snp_size | input | SW | Snooped store size code |
| res_vld | output | 1 | Check result valid |
| res_pass | output | 1 | Check passed |
| res_fault | output | 1 | Check had an alignment fault |

## Verification
The hardest cases to reach are collisions in a single cycle: a mark and a clear (or a passing check) for the same requester, and a check that races the mark it depends on. Random traffic also rarely makes a global slot and a snoop agree on both address and size. The stimulus therefore draws addresses from a pool of four aligned words with occasional misaligned offsets, and raises several request kinds in the same cycle. Directed sequences then build each collision on purpose, along with snoops of a matching and a mismatching size.

// File: rtl/excl_pkg.sv
package excl_pkg;
   localparam int unsigned MAX_AW = 64;

   // Nonzero when addr is not a multiple of 2**size_code bytes.
   function automatic logic misaligned(input logic [MAX_AW-1:0] addr,
                                       input int unsigned size_code);
      logic [MAX_AW-1:0] mask;
      mask = (size_code >= MAX_AW) ? '1 : ((MAX_AW'(1) << size_code) - MAX_AW'(1));
      return |(addr & mask);
   endfunction
endpackage

// File: rtl/excl_slot.sv
module excl_slot #(
   parameter int AW = 32,
   parameter int SW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_i,
   input  logic          set_shr_i,
   input  logic [AW-1:0] set_addr_i,
   input  logic [SW-1:0] set_size_i,
   input  logic          drop_loc_i,
   input  logic          snp_vld_i,
   input  logic [AW-1:0] snp_addr_i,
   input  logic [SW-1:0] snp_size_i,
   input  logic [AW-1:0] cmp_addr_i,
   input  logic [SW-1:0] cmp_size_i,
   output logic          loc_hit_o,
   output logic          glb_hit_o
);
   logic          loc_v, glb_v;
   logic [AW-1:0] loc_a, glb_a;
   logic [SW-1:0] loc_s, glb_s;
   logic          snp_hit;

   assign snp_hit = snp_vld_i && glb_v && (glb_a == snp_addr_i) && (glb_s == snp_size_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_v <= 1'b0;
         loc_a <= '0;
         loc_s <= '0;
      end else if (set_i) begin
         loc_v <= 1'b1;
         loc_a <= set_addr_i;
         loc_s <= set_size_i;
      end else if (drop_loc_i) begin
         loc_v <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_v <= 1'b0;
         glb_a <= '0;
         glb_s <= '0;
      end else if (set_i && set_shr_i) begin
         glb_v <= 1'b1;
         glb_a <= set_addr_i;
         glb_s <= set_size_i;
      end else if (snp_hit) begin
         glb_v <= 1'b0;
      end
   end

   assign loc_hit_o = loc_v && (loc_a == cmp_addr_i) && (loc_s == cmp_size_i);
   assign glb_hit_o = glb_v && (glb_a == cmp_addr_i) && (glb_s == cmp_size_i);
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
   parameter int NPROC     = 4,
   parameter int AW        = 32,
   parameter int SW        = 2,
   parameter bit CHK_ALIGN = 1'b1,
   localparam int PW       = (NPROC > 1) ? $clog2(NPROC) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mark_vld,
   input  logic [PW-1:0] mark_pid,
   input  logic [AW-1:0] mark_addr,
   input  logic [SW-1:0] mark_size,
   input  logic          mark_shr,
   input  logic          chk_vld,
   input  logic [PW-1:0] chk_pid,
   input  logic [AW-1:0] chk_addr,
   input  logic [SW-1:0] chk_size,
   input  logic          chk_shr,
   input  logic          clr_vld,
   input  logic [PW-1:0] clr_pid,
   input  logic          snp_vld,
   input  logic [AW-1:0] snp_addr,
   input  logic [SW-1:0] snp_size,
   output logic          res_vld,
   output logic          res_pass,
   output logic          res_fault
);
   initial begin
      if (NPROC < 1 || AW < 1 || AW > excl_pkg::MAX_AW || SW < 1)
         $error("excl_monitor: unsupported parameters");
   end

   logic [NPROC-1:0] loc_hit, glb_hit;
   logic             fault_now, pass_now, sel_loc, sel_glb;

   generate
      if (CHK_ALIGN) begin : g_align
         assign fault_now = chk_vld &&
            excl_pkg::misaligned(excl_pkg::MAX_AW'(chk_addr), int'(chk_size));
      end else begin : g_noalign
         assign fault_now = 1'b0;
      end
   endgenerate

   assign sel_loc  = (int'(chk_pid) < NPROC) && loc_hit[chk_pid];
   assign sel_glb  = (int'(chk_pid) < NPROC) && glb_hit[chk_pid];
   assign pass_now = chk_vld && !fault_now && sel_loc && (!chk_shr || sel_glb);

   generate
      for (genvar i = 0; i < NPROC; i++) begin : g_slot
         excl_slot #(.AW(AW), .SW(SW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (mark_vld && (int'(mark_pid) == i)),
            .set_shr_i  (mark_shr),
            .set_addr_i (mark_addr),
            .set_size_i (mark_size),
            .drop_loc_i ((clr_vld && (int'(clr_pid) == i)) ||
                         (pass_now && (int'(chk_pid) == i))),
            .snp_vld_i  (snp_vld),
            .snp_addr_i (snp_addr),
            .snp_size_i (snp_size),
            .cmp_addr_i (chk_addr),
            .cmp_size_i (chk_size),
            .loc_hit_o  (loc_hit[i]),
            .glb_hit_o  (glb_hit[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_vld   <= 1'b0;
         res_pass  <= 1'b0;
         res_fault <= 1'b0;
      end else begin
         res_vld   <= chk_vld;
         res_pass  <= pass_now;
         res_fault <= fault_now;
      end
   end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
   parameter int NPROC = 4,
   parameter int AW    = 32,
   parameter int SW    = 2,
   parameter int PW    = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mark_vld,
   input logic [PW-1:0] mark_pid,
   input logic          chk_vld,
   input logic [PW-1:0] chk_pid,
   input logic [AW-1:0] chk_addr,
   input logic [SW-1:0] chk_size,
   input logic          clr_vld,
   input logic [PW-1:0] clr_pid,
   input logic          res_vld,
   input logic          res_pass,
   input logic          res_fault
);
   logic misal;
   assign misal = excl_pkg::misaligned(excl_pkg::MAX_AW'(chk_addr), int'(chk_size));

   p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld |=> res_vld);
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_vld |=> !res_vld && !res_pass && !res_fault);
   p_fault_nopass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_fault |-> !res_pass);
   p_misaligned_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld && misal |=> res_fault);
   p_pass_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(chk_vld) && res_pass && chk_vld && chk_pid == $past(chk_pid) &&
      !$past(mark_vld && mark_pid == chk_pid) |=> !res_pass);
   p_clear_fails_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld && $past(clr_vld) && chk_pid == $past(clr_pid) &&
      !$past(mark_vld && mark_pid == clr_pid) |=> !res_pass);
endmodule

bind excl_monitor excl_monitor_chk #(.NPROC(NPROC), .AW(AW), .SW(SW), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mark_vld(mark_vld), .mark_pid(mark_pid),
   .chk_vld(chk_vld), .chk_pid(chk_pid), .chk_addr(chk_addr), .chk_size(chk_size),
   .clr_vld(clr_vld), .clr_pid(clr_pid),
   .res_vld(res_vld), .res_pass(res_pass), .res_fault(res_fault));

// File: tb/sim_excl_monitor.sv
`timescale 1ns/1ps
module sim_excl_monitor;
   localparam int NP = 4, AW = 32, SW = 2, PW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic mark_vld, mark_shr, chk_vld, chk_shr, clr_vld, snp_vld;
   logic [PW-1:0] mark_pid, chk_pid, clr_pid;
   logic [AW-1:0] mark_addr, chk_addr, snp_addr;
   logic [SW-1:0] mark_size, chk_size, snp_size;
   logic res_vld, res_pass, res_fault;

   always #2.5 clk = ~clk;

   excl_monitor #(.NPROC(NP), .AW(AW), .SW(SW)) u0 (.*);

   int checks = 0, fails = 0;
   logic          lv [NP], gv [NP];
   logic [AW-1:0] la [NP], ga [NP];
   logic [SW-1:0] ls [NP], gs [NP];

   task automatic idle();
      mark_vld = 0; chk_vld = 0; clr_vld = 0; snp_vld = 0;
      mark_pid = 0; chk_pid = 0; clr_pid = 0; mark_shr = 0; chk_shr = 0;
      mark_addr = 0; chk_addr = 0; snp_addr = 0;
      mark_size = 0; chk_size = 0; snp_size = 0;
   endtask

   function automatic logic bad_align(logic [AW-1:0] a, logic [SW-1:0] s);
      return (a % (32'd1 << s)) != 0;
   endfunction

   // Apply current inputs: compute expectation from the model, update model,
   // advance one cycle, then compare at the falling edge.
   task automatic step(string tag);
      logic ev, ep, ef;
      logic np_[NP];
      ev = chk_vld;
      ef = chk_vld && bad_align(chk_addr, chk_size);
      ep = chk_vld && !ef && lv[chk_pid] && la[chk_pid] == chk_addr && ls[chk_pid] == chk_size &&
           (!chk_shr || (gv[chk_pid] && ga[chk_pid] == chk_addr && gs[chk_pid] == chk_size));
      for (int i = 0; i < NP; i++) begin
         np_[i] = snp_vld && gv[i] && ga[i] == snp_addr && gs[i] == snp_size;
         if (mark_vld && mark_pid == i) begin
            lv[i] = 1; la[i] = mark_addr; ls[i] = mark_size;
            if (mark_shr) begin gv[i] = 1; ga[i] = mark_addr; gs[i] = mark_size; end
            else if (np_[i]) gv[i] = 0;
         end else begin
            if ((clr_vld && clr_pid == i) || (ep && chk_pid == i)) lv[i] = 0;
            if (np_[i]) gv[i] = 0;
         end
      end
      @(posedge clk);
      @(negedge clk);
      checks++;
      if ({res_vld, res_pass, res_fault} !== {ev, ep, ef}) begin
         fails++;
         $display("FAIL %s: vld/pass/fault got %b%b%b expected %b%b%b",
                  tag, res_vld, res_pass, res_fault, ev, ep, ef);
      end
      idle();
   endtask

   task automatic mk(int p, logic [AW-1:0] a, int s, bit sh, string tag);
      mark_vld = 1; mark_pid = PW'(p); mark_addr = a; mark_size = SW'(s); mark_shr = sh;
      step(tag);
   endtask
   task automatic ck(int p, logic [AW-1:0] a, int s, bit sh, string tag);
      chk_vld = 1; chk_pid = PW'(p); chk_addr = a; chk_size = SW'(s); chk_shr = sh;
      step(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      idle();
      for (int i = 0; i < NP; i++) begin
         lv[i] = 0; gv[i] = 0; la[i] = 0; ga[i] = 0; ls[i] = 0; gs[i] = 0;
      end
      repeat (3) @(negedge clk);
      checks++;
      if ({res_vld, res_pass, res_fault} !== 3'b000) begin
         fails++;
         $display("FAIL R9 reset: got %b%b%b expected 000", res_vld, res_pass, res_fault);
      end
      rst_n = 1'b1;
      @(negedge clk);
      step("R9 idle after reset");
      ck(0, 32'h200, 2, 1, "R3 check with no reservation");
      // R1/R3/R4
      mk(0, 32'h200, 2, 1, "R1 shareable mark");
      ck(0, 32'h200, 2, 1, "R3 shareable pass");
      ck(0, 32'h200, 2, 1, "R4 second check fails");
      // R1/R2
      mk(1, 32'h300, 3, 0, "R1 local-only mark");
      ck(1, 32'h300, 3, 1, "R1 global not set");
      ck(1, 32'h300, 3, 0, "R2 local pass after failed check");
      // size mismatch
      mk(2, 32'h400, 2, 0, "R2 mark");
      ck(2, 32'h400, 1, 0, "R2 size mismatch fails");
      ck(2, 32'h400, 2, 0, "R2 exact match passes");
      // R5
      mk(3, 32'h502, 1, 0, "R5 mark");
      ck(3, 32'h502, 2, 0, "R5 misaligned fault");
      ck(3, 32'h502, 1, 0, "R5 state unchanged after fault");
      // R6
      mk(0, 32'h600, 2, 0, "R6 mark p0");
      mk(1, 32'h600, 2, 0, "R6 mark p1");
      clr_vld = 1; clr_pid = 0; step("R6 clear p0");
      ck(1, 32'h600, 2, 0, "R6 other requester kept");
      ck(0, 32'h600, 2, 0, "R6 cleared requester fails");
      // R7
      mk(2, 32'h700, 2, 1, "R7 mark p2");
      mk(3, 32'h700, 2, 1, "R7 mark p3");
      snp_vld = 1; snp_addr = 32'h700; snp_size = 1; step("R7 snoop size mismatch");
      ck(2, 32'h700, 2, 1, "R7 mismatched snoop kept global");
      snp_vld = 1; snp_addr = 32'h700; snp_size = 2; step("R7 snoop hit");
      ck(3, 32'h700, 2, 1, "R7 global cleared");
      ck(3, 32'h700, 2, 0, "R7 local kept");
      // R8
      mk(1, 32'h800, 2, 0, "R8 first mark");
      mk(1, 32'h900, 2, 0, "R8 replacing mark");
      ck(1, 32'h800, 2, 0, "R8 old reservation gone");
      mark_vld = 1; mark_pid = 1; mark_addr = 32'h900; mark_size = 2;
      clr_vld = 1; clr_pid = 1; step("R8 mark with clear");
      ck(1, 32'h900, 2, 0, "R8 mark wins over clear");
      // R9 same-cycle race
      mark_vld = 1; mark_pid = 0; mark_addr = 32'hA00; mark_size = 2;
      chk_vld = 1; chk_pid = 0; chk_addr = 32'hA00; chk_size = 2;
      step("R9 check sees old state");
      ck(0, 32'hA00, 2, 0, "R9 next check passes");
      // random mix (R1..R8 via model)
      for (int n = 0; n < 4000; n++) begin
         mark_vld = ($urandom % 100) < 30;
         mark_pid = PW'($urandom); mark_shr = $urandom;
         mark_addr = 32'h100 + ($urandom % 4) * 8; mark_size = SW'($urandom);
         chk_vld = ($urandom % 100) < 45;
         chk_pid = PW'($urandom); chk_shr = $urandom;
         chk_addr = 32'h100 + ($urandom % 4) * 8 + ((($urandom % 6) == 0) ? $urandom % 8 : 0);
         chk_size = SW'($urandom);
         clr_vld = ($urandom % 100) < 10; clr_pid = PW'($urandom);
         snp_vld = ($urandom % 100) < 15;
         snp_addr = 32'h100 + ($urandom % 4) * 8; snp_size = SW'($urandom);
         step("R4 random mix");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule